// File: doc/BRIEF.md
# Expanded-Mode External Interrupt Capture Unit

This block takes an already-encoded external interrupt vector from eight active-low, level-sensitive pins and turns it into a masked, priority-qualified interrupt request for a processor core. External logic posts and prioritises the individual sources and drives the inverted vector number onto the pins. The block synchronises the pins and accepts a value only after it has settled. It inverts the value to recover the vector, drops vectors that carry no request, and compares the vector's priority with the core's current priority.

A single global enable bit gates every request. When the core acknowledges an interrupt, the two halves of the vector are latched into two registers for handler selection. Optionally, the enable bit is saved and cleared at the same moment, which locks out further hardware requests until software restores it with a strobe. A small register port gives access to the enable bit and to the two nibble registers.

Top module: `xint_capture`

## Requirements
- R1: `irq_vec_o` equals the bitwise inverse of the settled pin levels, with pin 0 as bit 0 and pin 7 as bit 7; idle pins (all high) give vector 0.
- R2: A pin value is taken only when two consecutive synchronised samples agree. A value applied just after a falling clock edge appears on `irq_vec_o` after the fourth rising edge, and a value held for a single clock period is never taken.
- R3: Vectors 0 through 7 never raise `irq_o`, and vector 8 can raise it.
- R4: The priority is `irq_vec_o[7:3]`. `irq_o` requires this priority to be strictly greater than `cur_prio_i`, or to equal 31.
- R5: `irq_o` is low whenever the enable bit (address 0, bit 0) is 0; it resets to 0.
- R6: A write to address 0 stores only `reg_wdata_i[0]`; reading address 0 returns bits 7:1 as zero.
- R7: An `ack_i` pulse while `irq_o` is high latches `irq_vec_o[7:4]` into address 1 bits 3:0 and `irq_vec_o[3:0]` into address 2 bits 3:0 (upper bits read zero); `ack_i` while `irq_o` is low has no effect.
- R8: The nibble registers hold their value between accepted acknowledges, whatever the pins do.
- R9: With `save_clr_en_i` high, an accepted acknowledge copies the enable bit to a saved copy and clears the enable bit; with it low, the enable bit is unchanged.
- R10: A `restore_i` pulse reloads the enable bit from the saved copy. In the same cycle a write to address 0 takes precedence over a restore, and a restore takes precedence over an acknowledge clear.
- R11: Address 3 (pending) reads zero, and writes to it change neither `irq_o` nor any register.
- R12: Requests are level-sensitive: `irq_o` stays high as long as the pins hold a qualifying vector and falls once they return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xint_ni | input | 8 | Inverted encoded vector pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| cur_prio_i | input | 5 | Core's current priority |
| ack_i | input | 1 | Core acknowledges the pending interrupt |
| save_clr_en_i | input | 1 | Save and clear the enable bit on acknowledge |
| restore_i | input | 1 | Reload the enable bit from the saved copy |
| irq_o | output | 1 | Qualified interrupt request |
| irq_vec_o | output | 8 | Settled vector number |

## Verification
The bench targets the edges of the vector space: vectors 7 and 8 around the ignore boundary, and priorities equal to, one below and one above the current priority. A comparator using >= instead of > would fire on the equal case, and one missing the top-priority exception would stay silent at 31. It measures the exact four-edge capture latency and drives a one-period pin pulse that a single-sample filter would latch as a false vector. It also checks that an acknowledge taken while no request is raised leaves the nibble registers alone, that the save-and-clear and restore paths move the enable bit in the stated precedence, and that pending-address writes leave every output untouched.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MASK = 2'd0,
    ADDR_MAP  = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_PEND = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] pin_ni,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] meta_q, sync_q, prev_q, vec_q;

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[b] <= 1'b1;
        sync_q[b] <= 1'b1;
        prev_q[b] <= 1'b1;
      end else begin
        meta_q[b] <= pin_ni[b];
        sync_q[b] <= meta_q[b];
        prev_q[b] <= sync_q[b];
      end
    end
  end

  // accept only a value seen on two consecutive samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               vec_q <= '0;
    else if (sync_q == prev_q) vec_q <= ~sync_q;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/xint_qual.sv
module xint_qual #(
  parameter int unsigned PRIO_W = 5
) (
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              en_i,
  output logic              req_o
);
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  logic live, wins;

  always_comb begin
    live  = |prio_i;
    wins  = (prio_i > cur_prio_i) || (prio_i == PRIO_MAX);
    req_o = en_i && live && wins;
  end
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  output logic [VEC_W-1:0]  rdata_o,
  input  logic              take_i,
  input  logic              save_clr_en_i,
  input  logic              restore_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              mask_o,
  output logic              saved_o,
  output logic [VEC_W/2-1:0] map_nib_o,
  output logic [VEC_W/2-1:0] low_nib_o
);
  localparam int unsigned NIB_W = VEC_W / 2;
  localparam int unsigned PAD_W = VEC_W - NIB_W;

  logic             mask_q, saved_q;
  logic [NIB_W-1:0] map_q, low_q;
  logic             mask_wr;
  logic             unused_wdata;

  assign mask_wr      = we_i && (addr_i == ADDR_MASK);
  assign unused_wdata = ^wdata_i[VEC_W-1:1];

  // write > restore > acknowledge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b0;
      saved_q <= 1'b0;
    end else begin
      if (take_i && save_clr_en_i) saved_q <= mask_q;
      if (mask_wr)                        mask_q <= wdata_i[0];
      else if (restore_i)                 mask_q <= saved_q;
      else if (take_i && save_clr_en_i)   mask_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      low_q <= '0;
    end else if (take_i) begin
      map_q <= vec_i[VEC_W-1 -: NIB_W];
      low_q <= vec_i[NIB_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_MASK: rdata_o = {{(VEC_W-1){1'b0}}, mask_q};
      ADDR_MAP:  rdata_o = {{PAD_W{1'b0}}, map_q};
      ADDR_LOW:  rdata_o = {{PAD_W{1'b0}}, low_q};
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o    = mask_q;
  assign saved_o   = saved_q;
  assign map_nib_o = map_q;
  assign low_nib_o = low_q;
endmodule

// File: rtl/xint_capture.sv
module xint_capture
  import xint_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned PRIO_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  xint_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [VEC_W-1:0]  reg_wdata_i,
  output logic [VEC_W-1:0]  reg_rdata_o,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              ack_i,
  input  logic              save_clr_en_i,
  input  logic              restore_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int unsigned NIB_W = VEC_W / 2;

  logic [VEC_W-1:0] vec;
  logic             mask_en, saved_en, req, take;
  logic [NIB_W-1:0] map_nib, low_nib;

  xint_sync #(.VEC_W(VEC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (xint_ni),
    .vec_o  (vec)
  );

  xint_qual #(.PRIO_W(PRIO_W)) u_qual (
    .prio_i     (vec[VEC_W-1 -: PRIO_W]),
    .cur_prio_i (cur_prio_i),
    .en_i       (mask_en),
    .req_o      (req)
  );

  assign take = ack_i && req;

  xint_regs #(.VEC_W(VEC_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .rdata_o       (reg_rdata_o),
    .take_i        (take),
    .save_clr_en_i (save_clr_en_i),
    .restore_i     (restore_i),
    .vec_i         (vec),
    .mask_o        (mask_en),
    .saved_o       (saved_en),
    .map_nib_o     (map_nib),
    .low_nib_o     (low_nib)
  );

  assign irq_o     = req;
  assign irq_vec_o = vec;
endmodule

// File: rtl/xint_capture_chk.sv
module xint_capture_chk #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned PRIO_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [VEC_W-1:0]  reg_wdata_i,
  input logic [VEC_W-1:0]  reg_rdata_o,
  input logic [PRIO_W-1:0] cur_prio_i,
  input logic              ack_i,
  input logic              save_clr_en_i,
  input logic              restore_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic              mask_en,
  input logic              saved_en,
  input logic [VEC_W/2-1:0] map_nib,
  input logic [VEC_W/2-1:0] low_nib
);
  localparam int unsigned NIB_W = VEC_W / 2;
  localparam logic [PRIO_W-1:0] PMAX = '1;

  logic mask_wr;
  assign mask_wr = reg_we_i && (reg_addr_i == 2'd0);

  AST_NO_LOW_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o[VEC_W-1 -: PRIO_W] != '0)); // R3

  AST_PRIO_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irq_vec_o[VEC_W-1 -: PRIO_W] > cur_prio_i) ||
               (irq_vec_o[VEC_W-1 -: PRIO_W] == PMAX))); // R4

  AST_MASK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_en |-> !irq_o); // R5

  AST_MASK_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[VEC_W-1:1] == '0)); // R6

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> (mask_en == $past(reg_wdata_i[0]))); // R6

  AST_NIB_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (map_nib == $past(irq_vec_o[VEC_W-1 -: NIB_W]) &&
                          low_nib == $past(irq_vec_o[NIB_W-1:0]))); // R7

  AST_NIB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> ($stable(map_nib) && $stable(low_nib))); // R8

  AST_SAVE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && save_clr_en_i && !mask_wr && !restore_i)
      |=> (!mask_en && saved_en == $past(mask_en))); // R9

  AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !mask_wr) |=> (mask_en == $past(saved_en))); // R10
endmodule

bind xint_capture xint_capture_chk #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .cur_prio_i    (cur_prio_i),
  .ack_i         (ack_i),
  .save_clr_en_i (save_clr_en_i),
  .restore_i     (restore_i),
  .irq_o         (irq_o),
  .irq_vec_o     (irq_vec_o),
  .mask_en       (mask_en),
  .saved_en      (saved_en),
  .map_nib       (map_nib),
  .low_nib       (low_nib)
);

// File: tb/xint_capture_test.sv
`timescale 1ns/1ps
module xint_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] xint_n = 8'hFF;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] cur = 5'd0;
  logic       ack = 1'b0;
  logic       save_en = 1'b0;
  logic       restore = 1'b0;
  logic       irq;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xint_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .xint_ni(xint_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cur_prio_i(cur), .ack_i(ack), .save_clr_en_i(save_en), .restore_i(restore),
    .irq_o(irq), .irq_vec_o(vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk); xint_n = ~v;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 2'd0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_cur(input logic [4:0] p);
    @(negedge clk); cur = p; #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R5 reset irq", irq, 0);
    check("R1 reset vec", vec, 8'h00);
    reg_read(2'd0, d); check("R5 reset mask", d, 8'h00);
    reg_read(2'd1, d); check("R7 reset map", d, 8'h00);
    reg_read(2'd2, d); check("R7 reset low", d, 8'h00);
  endtask

  task automatic t_vectors();
    reg_write(2'd0, 8'h01);
    set_cur(5'd0);
    set_pins(8'h05); check("R3 vec5 vec", vec, 8'h05); check("R3 vec5 irq", irq, 0);
    set_pins(8'h07); check("R3 vec7 irq", irq, 0);
    set_pins(8'h08); check("R3 vec8 irq", irq, 1); check("R1 vec8", vec, 8'h08);
    set_pins(8'hA5); check("R1 bit order", vec, 8'hA5);
  endtask

  task automatic t_latency();
    @(negedge clk); xint_n = ~8'h3C;
    repeat (3) @(posedge clk); #1;
    check("R2 not yet at edge 3", vec, 8'hA5);
    @(posedge clk); #1;
    check("R2 taken at edge 4", vec, 8'h3C);
    repeat (3) @(posedge clk);
    @(negedge clk); xint_n = ~8'h77;
    @(negedge clk); xint_n = ~8'h3C;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check("R2 one-period pulse rejected", vec, 8'h3C);
    end
  endtask

  task automatic t_priority();
    set_pins(8'h40);
    set_cur(5'd7);  check("R4 prio above", irq, 1);
    set_cur(5'd8);  check("R4 prio equal", irq, 0);
    set_cur(5'd9);  check("R4 prio below", irq, 0);
    set_pins(8'hF0); set_cur(5'd31); check("R4 prio 30 vs 31", irq, 0);
    set_pins(8'hF8); check("R4 prio 31 vs 31", irq, 1);
    set_cur(5'd0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    set_pins(8'h40);
    reg_write(2'd0, 8'hFF); reg_read(2'd0, d); check("R6 only bit0 kept", d, 8'h01);
    reg_write(2'd0, 8'h00); #1; check("R5 masked irq", irq, 0);
    reg_write(2'd0, 8'hFE); reg_read(2'd0, d); check("R6 bit0 clear", d, 8'h00);
    #1; check("R5 still masked", irq, 0);
    reg_write(2'd0, 8'h01); #1; check("R5 unmasked irq", irq, 1);
  endtask

  task automatic t_nibbles();
    logic [7:0] d;
    set_pins(8'hB6); check("R7 irq before ack", irq, 1);
    pulse_ack();
    reg_read(2'd1, d); check("R7 upper nibble", d, 8'h0B);
    reg_read(2'd2, d); check("R7 lower nibble", d, 8'h06);
    set_pins(8'h9C);
    reg_read(2'd1, d); check("R8 map held", d, 8'h0B);
    reg_read(2'd2, d); check("R8 low held", d, 8'h06);
    reg_write(2'd0, 8'h00);
    pulse_ack();
    reg_read(2'd1, d); check("R7 ack ignored map", d, 8'h0B);
    reg_read(2'd2, d); check("R7 ack ignored low", d, 8'h06);
    reg_write(2'd0, 8'h01);
  endtask

  task automatic t_save_restore();
    logic [7:0] d;
    save_en = 1'b0;
    pulse_ack();
    reg_read(2'd0, d); check("R9 no clear when disabled", d, 8'h01);
    save_en = 1'b1;
    pulse_ack();
    save_en = 1'b0;
    reg_read(2'd0, d); check("R9 cleared on ack", d, 8'h00);
    #1; check("R9 irq locked out", irq, 0);
    reg_read(2'd1, d); check("R7 map 9C", d, 8'h09);
    reg_read(2'd2, d); check("R7 low 9C", d, 8'h0C);
    @(negedge clk); restore = 1'b1;
    @(negedge clk); restore = 1'b0;
    reg_read(2'd0, d); check("R10 restored", d, 8'h01);
    #1; check("R10 irq back", irq, 1);
    @(negedge clk); restore = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h00;
    @(negedge clk); restore = 1'b0; we = 1'b0;
    reg_read(2'd0, d); check("R10 write beats restore", d, 8'h00);
    reg_write(2'd0, 8'h01);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    reg_write(2'd3, 8'hFF);
    reg_read(2'd3, d); check("R11 pend reads zero", d, 8'h00);
    #1; check("R11 irq unchanged", irq, 1);
    reg_read(2'd0, d); check("R11 mask unchanged", d, 8'h01);
    reg_read(2'd1, d); check("R11 map unchanged", d, 8'h09);
  endtask

  task automatic t_level();
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (i % 5 == 0) check("R12 held level", irq, 1);
    end
    set_pins(8'h00);
    check("R12 idle irq", irq, 0);
    check("R12 idle vec", vec, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_vectors();
    t_latency();
    t_priority();
    t_mask();
    t_nibbles();
    t_save_restore();
    t_pending();
    t_level();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule